// File: doc/BRIEF.md
# Then-Else Predication Mask Unit

This unit sits in the decode stage and lets a short if-then-else run without any branch. A single prefix instruction supplies a condition bit and a mask of up to eight two-bit slot codes. Each slot describes one of the instructions that follow the prefix. A slot can mark its instruction as part of the then-clause or the else-clause, or it can leave the instruction unpredicated. The instructions that follow carry no predicate bits of their own. For each instruction that decode issues, the unit answers with an enable. An instruction on the path not taken is turned into a NOP, and fetch is never redirected.

The pending slots are held in a register that shifts right by one slot for every issued instruction. Once every slot has been consumed, each instruction executes. When a new prefix arrives, it replaces whatever remains of the old mask and the old condition. This is how compound conditions (AND, OR) are built from chained prefixes. A flush clears the pending mask. The mask and the condition are visible on output ports and can be loaded back, so that they survive an interrupt.

Top module: `pred_mask_unit`

## Requirements
- R1: Reset leaves the mask empty (all slot codes 00) and the latched condition at 0. The first instruction issued after reset executes.
- R2: Slot k of the mask sits at bits [2k+1:2k], and slot 0 applies to the first instruction issued after the prefix. The codes are 01 for then, 10 for else and 00 for unpredicated. Code 11 is reserved and behaves like 00.
- R3: A then-slot executes exactly when the latched condition is 1. An else-slot executes exactly when the latched condition is 0. issue_en is valid in the same cycle as issue.
- R4: The mask advances by one slot only in a cycle where issue is high. In cycles with no issue, prefix, flush or restore, the mask and the condition hold their values.
- R5: After eight issued instructions with no new prefix, the mask is empty and every further instruction executes.
- R6: A prefix replaces the whole mask and the condition at the next edge. An instruction issued in the same cycle as the prefix is judged by the old state and does not shift the new mask.
- R7: A flush empties the mask and clears the condition at the next edge. Flush takes priority over restore and over a prefix.
- R8: sv_mask and sv_cond show the current mask and condition. restore_valid loads restore_mask and restore_cond at the next edge, and takes priority over a prefix.
- R9: issue_en is low whenever issue is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A predicate prefix is decoded this cycle |
| pred_cond | input | 1 | Condition value carried by the prefix |
| pred_mask | input | 2*SLOTS | Slot codes carried by the prefix |
| issue | input | 1 | An ordinary instruction issues this cycle |
| flush | input | 1 | Pipeline flush or interrupt entry |
| restore_valid | input | 1 | Reload the saved predicate state |
| restore_mask | input | 2*SLOTS | Mask value to reload |
| restore_cond | input | 1 | Condition value to reload |
| issue_en | output | 1 | 1 = execute the issuing instruction, 0 = squash it to a NOP |
| sv_mask | output | 2*SLOTS | Current pending mask, for saving |
| sv_cond | output | 1 | Current latched condition, for saving |

## Verification
issue_en is a combinational function of issue and the registered state, so it is due in the very cycle of the issue. The bench drives its inputs at the falling edge and samples issue_en 1 ns later. Prefix, restore, flush and shift effects appear in sv_mask and sv_cond one rising edge after the cycle that caused them, and the bench reads those ports at the following falling edge. Because the sweep issues eight instructions right after each prefix, every expected enable falls in a known cycle. The expected enables come from the slot pattern and the condition.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'b00,
    SLOT_THEN = 2'b01,
    SLOT_ELSE = 2'b10,
    SLOT_RSVD = 2'b11
  } slot_t;

  // Decide whether an instruction governed by slot code 'code' runs.
  function automatic logic slot_runs(input logic [1:0] code, input logic cond);
    case (slot_t'(code))
      SLOT_THEN: slot_runs = cond;
      SLOT_ELSE: slot_runs = ~cond;
      default:   slot_runs = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pmu_mask_shifter.sv
module pmu_mask_shifter #(
  parameter int SLOTS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          load,
  input  logic [SLOTS*pmu_pkg::SLOT_W-1:0] load_val,
  input  logic                          shift,
  output logic [SLOTS*pmu_pkg::SLOT_W-1:0] mask_q,
  output logic [pmu_pkg::SLOT_W-1:0]       head
);
  localparam int SW = pmu_pkg::SLOT_W;
  localparam int MW = SLOTS * SW;

  logic [MW-1:0] mask_d;

  // Per-slot next value: each slot takes its upper neighbour on a shift,
  // the top slot takes the empty code.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [SW-1:0] upper;
    if (k == SLOTS - 1) begin : g_top
      assign upper = pmu_pkg::SLOT_NONE;
    end else begin : g_mid
      assign upper = mask_q[(k+1)*SW +: SW];
    end
    always_comb begin
      if (clr)        mask_d[k*SW +: SW] = pmu_pkg::SLOT_NONE;
      else if (load)  mask_d[k*SW +: SW] = load_val[k*SW +: SW];
      else if (shift) mask_d[k*SW +: SW] = upper;
      else            mask_d[k*SW +: SW] = mask_q[k*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign head = mask_q[SW-1:0];
endmodule

// File: rtl/pmu_cond_latch.sv
module pmu_cond_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic load_val,
  output logic cond_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cond_q <= 1'b0;
    else if (clr)  cond_q <= 1'b0;
    else if (load) cond_q <= load_val;
  end
endmodule

// File: rtl/pmu_slot_decode.sv
module pmu_slot_decode (
  input  logic       issue,
  input  logic [1:0] code,
  input  logic       cond,
  output logic       run
);
  assign run = issue & pmu_pkg::slot_runs(code, cond);
endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit #(
  parameter int SLOTS = 8,
  localparam int MW = SLOTS * pmu_pkg::SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pred_valid,
  input  logic          pred_cond,
  input  logic [MW-1:0] pred_mask,
  input  logic          issue,
  input  logic          flush,
  input  logic          restore_valid,
  input  logic [MW-1:0] restore_mask,
  input  logic          restore_cond,
  output logic          issue_en,
  output logic [MW-1:0] sv_mask,
  output logic          sv_cond
);
  // Named control events, also watched by the checker.
  logic          clr_now;
  logic          load_now;
  logic          shift_now;
  logic [MW-1:0] load_mask;
  logic          load_cond;
  logic [1:0]    head_slot;
  logic          cond_q;

  // Priority: flush, then restore, then prefix, then issue shift.
  assign clr_now   = flush;
  assign load_now  = ~flush & (restore_valid | pred_valid);
  assign load_mask = restore_valid ? restore_mask : pred_mask;
  assign load_cond = restore_valid ? restore_cond : pred_cond;
  assign shift_now = issue & ~flush & ~restore_valid & ~pred_valid;

  pmu_mask_shifter #(.SLOTS(SLOTS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_now),
    .load     (load_now),
    .load_val (load_mask),
    .shift    (shift_now),
    .mask_q   (sv_mask),
    .head     (head_slot)
  );

  pmu_cond_latch u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_now),
    .load     (load_now),
    .load_val (load_cond),
    .cond_q   (cond_q)
  );

  pmu_slot_decode u_dec (
    .issue (issue),
    .code  (head_slot),
    .cond  (cond_q),
    .run   (issue_en)
  );

  assign sv_cond = cond_q;
endmodule

// File: rtl/pred_mask_unit_chk.sv
module pred_mask_unit_chk #(
  parameter int SLOTS = 8,
  localparam int MW = SLOTS * 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pred_valid,
  input logic          pred_cond,
  input logic [MW-1:0] pred_mask,
  input logic          issue,
  input logic          flush,
  input logic          restore_valid,
  input logic [MW-1:0] restore_mask,
  input logic          restore_cond,
  input logic          issue_en,
  input logic [MW-1:0] sv_mask,
  input logic          sv_cond
);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> !issue_en);

  p_empty_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_mask == '0) && issue |-> issue_en);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue && !pred_valid && !flush && !restore_valid
    |=> $stable(sv_mask) && $stable(sv_cond));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !pred_valid && !flush && !restore_valid
    |=> sv_mask == ($past(sv_mask) >> 2) && $stable(sv_cond));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> sv_mask == '0 && !sv_cond);

  p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !flush && !restore_valid
    |=> sv_mask == $past(pred_mask) && sv_cond == $past(pred_cond));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid && !flush
    |=> sv_mask == $past(restore_mask) && sv_cond == $past(restore_cond));
endmodule

bind pred_mask_unit pred_mask_unit_chk #(.SLOTS(SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pred_valid    (pred_valid),
  .pred_cond     (pred_cond),
  .pred_mask     (pred_mask),
  .issue         (issue),
  .flush         (flush),
  .restore_valid (restore_valid),
  .restore_mask  (restore_mask),
  .restore_cond  (restore_cond),
  .issue_en      (issue_en),
  .sv_mask       (sv_mask),
  .sv_cond       (sv_cond)
);

// File: tb/pred_mask_unit_bench.sv
module pred_mask_unit_bench;
  localparam int SLOTS = 8;
  localparam int MW = 2 * SLOTS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pred_valid = 1'b0, pred_cond = 1'b0;
  logic [MW-1:0] pred_mask = '0;
  logic          issue = 1'b0, flush = 1'b0;
  logic          restore_valid = 1'b0, restore_cond = 1'b0;
  logic [MW-1:0] restore_mask = '0;
  logic          issue_en;
  logic [MW-1:0] sv_mask;
  logic          sv_cond;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_mask_unit #(.SLOTS(SLOTS)) u_pred_mask_unit (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_cond(pred_cond),
    .pred_mask(pred_mask), .issue(issue), .flush(flush),
    .restore_valid(restore_valid), .restore_mask(restore_mask),
    .restore_cond(restore_cond), .issue_en(issue_en), .sv_mask(sv_mask),
    .sv_cond(sv_cond)
  );

  // Bit k of pat = 1 -> slot k is then (01), else slot k is else (10).
  function automatic logic [MW-1:0] te_mask(input logic [SLOTS-1:0] pat);
    logic [MW-1:0] m;
    for (int k = 0; k < SLOTS; k++) m[2*k +: 2] = pat[k] ? 2'b01 : 2'b10;
    return m;
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_state(input logic [MW-1:0] em, input logic ec, input string tag);
    @(negedge clk);
    n_checks++;
    if (sv_mask !== em || sv_cond !== ec) begin
      n_fail++;
      $display("FAIL %s actual=%h/%0b expected=%h/%0b", tag, sv_mask, sv_cond, em, ec);
    end
  endtask

  // One cycle of stimulus; issue_en is checked in the same cycle.
  task automatic cyc(input logic pv, input logic pc, input logic [MW-1:0] pm,
                     input logic iss, input logic fl, input logic rv,
                     input logic [MW-1:0] rm, input logic rc,
                     input logic exp_en, input string tag);
    @(negedge clk);
    pred_valid = pv; pred_cond = pc; pred_mask = pm; issue = iss; flush = fl;
    restore_valid = rv; restore_mask = rm; restore_cond = rc;
    #1 check_bit(issue_en, exp_en, tag);
    @(posedge clk);
    #1;
    pred_valid = 0; issue = 0; flush = 0; restore_valid = 0;
  endtask

  task automatic prefix(input logic [MW-1:0] m, input logic c);
    cyc(1, c, m, 0, 0, 0, '0, 0, 0, "R9 prefix cycle no issue");
  endtask

  task automatic iss(input logic exp, input string tag);
    cyc(0, 0, '0, 1, 0, 0, '0, 0, exp, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, 0, 0, 0, '0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] saved_m;
    logic          saved_c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check_state('0, 0, "R1 reset state");
    iss(1, "R1 issue after reset executes");
    idle("R9 idle enable low");

    // R2 R3 R5 sweep of every then/else pattern under both conditions
    for (int p = 0; p < 256; p++) begin
      for (int c = 0; c < 2; c++) begin
        prefix(te_mask(p[7:0]), c[0]);
        for (int k = 0; k < SLOTS; k++)
          iss(p[k] ? c[0] : ~c[0], "R3 R2 slot enable");
        iss(1, "R5 empty after eight");
      end
    end

    // R4 gaps do not advance the mask
    prefix(16'h0009, 1);               // slot0 then, slot1 else
    idle("R4 gap"); idle("R4 gap"); idle("R4 gap");
    check_state(16'h0009, 1, "R4 hold during gaps");
    iss(1, "R4 then after gaps");
    idle("R4 gap");
    iss(0, "R4 else after gap");
    check_state('0, 1, "R4 drained");

    // R2 unpredicated and reserved codes
    prefix(16'h001C, 0);               // slot0 00, slot1 11, slot2 01
    iss(1, "R2 code 00 runs");
    iss(1, "R2 code 11 runs");
    iss(0, "R2 then with cond 0 squashed");

    // R6 overwrite, simultaneous issue judged by old state
    prefix(16'hAAAA, 1);
    iss(0, "R6 old else squashed");
    cyc(1, 1, 16'h0055, 1, 0, 0, '0, 0, 0, "R6 same-cycle issue uses old state");
    check_state(16'h0055, 1, "R6 new mask loaded whole");
    for (int k = 0; k < 4; k++) iss(1, "R6 new then slots");
    iss(1, "R6 old tail discarded");

    // R7 flush
    prefix(16'hAAAA, 1);
    iss(0, "R7 else before flush");
    cyc(0, 0, '0, 0, 1, 0, '0, 0, 0, "R7 flush cycle");
    check_state('0, 0, "R7 flush empties");
    iss(1, "R7 runs after flush");
    cyc(1, 1, 16'hAAAA, 0, 1, 1, 16'h5555, 1, 0, "R7 flush with prefix and restore");
    check_state('0, 0, "R7 flush wins");

    // R8 save and restore
    prefix(te_mask(8'b1011_0110), 1);
    iss(0, "R8 slot0"); iss(1, "R8 slot1");
    check_state(te_mask(8'b1011_0110) >> 4, 1, "R8 visible state");
    saved_m = sv_mask; saved_c = sv_cond;
    cyc(0, 0, '0, 0, 1, 0, '0, 0, 0, "R8 interrupt flush");
    cyc(1, 0, 16'h5555, 0, 0, 1, saved_m, saved_c, 0, "R8 restore over prefix");
    check_state(te_mask(8'b1011_0110) >> 4, 1, "R8 restore wins");
    iss(1, "R8 slot2"); iss(0, "R8 slot3"); iss(1, "R8 slot4");
    iss(1, "R8 slot5"); iss(0, "R8 slot6"); iss(1, "R8 slot7");
    iss(1, "R5 R8 empty after restore");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule